// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block keeps recently used translations from a 20-bit virtual page number to a physical frame number, so that most memory references skip the page-table walk. It has 64 entries for 4 KB pages, arranged as 16 sets of 4 ways. Together they cover 256 KB of virtual space. Each entry also holds the writable and user-access permission bits taken from the page table entry. A lookup that hits checks the access against these bits and does not need a walk.

A lookup is accepted in any cycle, and its result appears one clock later. When a lookup misses, the hardware page walker supplies the missing translation through the refill port. Software does not load entries. A write to the root page-table register is signalled on the flush input, and it drops every entry. A single-page invalidate removes only the translation for the virtual page it names.

Top module: `xlat_cache`

## Requirements
- R1: A lookup presented in cycle t (`lk_valid`=1) is answered in cycle t+1 with `rsp_valid`=1. When `lk_valid`=0, all response outputs in the next cycle are 0. All outputs are 0 after reset.
- R2: The set index is `vpn[3:0]` and the tag is `vpn[19:4]`. Up to four distinct pages that share an index are all held at the same time and all hit.
- R3: A miss answers with `rsp_hit`=0, `rsp_fault`=0 and `rsp_pfn`=0.
- R4: A hit answers with `rsp_hit`=1 and the stored frame number. `rsp_fault`=1 when the access is a write to an entry without write permission, or a user access to an entry without user permission. A faulting hit still reports the hit and changes no entry.
- R5: A refill stores the frame and permissions for its page. A refill of a page already held overwrites that entry in place, so a page never occupies two ways.
- R6: A refill into a set with an empty way takes the lowest-numbered empty way. No valid entry is evicted while a way is empty.
- R7: In a full set, a refill replaces the way chosen by a 3-bit tree pseudo-LRU. If the root bit is 0, the victim is way 1 when the left bit is 1 and way 0 otherwise. If the root bit is 1, the victim is way 3 when the right bit is 1 and way 2 otherwise. Using way 0 sets root=1 and left=1. Using way 1 sets root=1 and left=0. Using way 2 sets root=0 and right=1. Using way 3 sets root=0 and right=0.
- R8: A flush invalidates all 64 entries. A refill in the same cycle as a flush is discarded.
- R9: An invalidate removes only the entry for its page, and every other entry stays. A refill in the same cycle as an invalidate is discarded.
- R10: A lookup sees the contents as they were before any refill, flush or invalidate in the same cycle.
- R11: Every lookup hit and every refill counts as a use of that way for R7. If a lookup hit and a refill fall in the same set and cycle, the hit is applied first. A flush returns all replacement bits to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | Lookup is a store |
| lk_user | input | 1 | Lookup comes from user mode |
| flush_all | input | 1 | Root table register written; drop all entries |
| inv_valid | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | Page to invalidate |
| fill_valid | input | 1 | Refill from the page walker |
| fill_vpn | input | 20 | Page being refilled |
| fill_pfn | input | 20 | Frame number for the refill |
| fill_wr | input | 1 | Write permission of the refilled page |
| fill_usr | input | 1 | User permission of the refilled page |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Hit that breaks the stored permissions |
| rsp_pfn | output | 20 | Frame number on a hit, else 0 |

## Verification
A refill can arrive in the same cycle as a flush or an invalidate. A refill can also land in the set and cycle of a lookup hit. The directed steps place a refill in the same cycle as a flush and as an invalidate, and later lookups show that the refill never took effect. A lookup of a page in the same cycle as its refill must miss, and the next lookup of that page must hit. A random phase mixes all four operations over a small pool of pages. The model applies the stated priorities and the hit-then-refill replacement order, and its hit, frame, fault and eviction results are compared with the outputs on every clock.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Source of the way a refill writes into
  typedef enum logic [1:0] {
    FS_MATCH = 2'd0,
    FS_FREE  = 2'd1,
    FS_PLRU  = 2'd2
  } fill_src_e;

  // Access breaks the cached permissions
  function automatic logic perm_fault(input logic is_wr, input logic is_usr,
                                      input logic ent_wr, input logic ent_usr);
    return (is_wr & ~ent_wr) | (is_usr & ~ent_usr);
  endfunction

endpackage

// File: rtl/xlat_way_cmp.sv
module xlat_way_cmp #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]            key,
  output logic [WAYS-1:0]             match,
  output logic                        any,
  output logic [WAY_W-1:0]            way
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == key);
  end

  assign any = |match;

  always_comb begin
    way = '0;
    for (int i = 0; i < WAYS; i++)
      if (match[i]) way = WAY_W'(i);
  end
endmodule

// File: rtl/xlat_plru_bank.sv
module xlat_plru_bank #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_set,
  input  logic [WAY_W-1:0] a_way,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_set,
  input  logic [WAY_W-1:0] b_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_victim
);
  // heap-ordered tree: node 1 is the root, bit=1 steers right
  function automatic logic [WAYS-1:0] tree_touch(input logic [WAYS-1:0] t,
                                                 input logic [WAY_W-1:0] w);
    logic [WAYS-1:0] r;
    int unsigned n;
    r = t;
    n = WAYS + int'(w);
    for (int l = 0; l < WAY_W; l++) begin
      r[n >> 1] = ~n[0];
      n = n >> 1;
    end
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] tree_victim(input logic [WAYS-1:0] t);
    int unsigned n;
    n = 1;
    for (int l = 0; l < WAY_W; l++)
      n = 2 * n + (t[n] ? 1 : 0);
    return WAY_W'(n - WAYS);
  endfunction

  logic [SETS-1:0][WAYS-1:0] tree_q, tree_d;

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      tree_d[s] = tree_q[s];
      if (a_en && a_set == IDX_W'(s)) tree_d[s] = tree_touch(tree_d[s], a_way);
      if (b_en && b_set == IDX_W'(s)) tree_d[s] = tree_touch(tree_d[s], b_way);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tree_q <= '0;
    else if (clr) tree_q <= '0;
    else          tree_q <= tree_d;
  end

  assign rd_victim = tree_victim(tree_q[rd_set]);
endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel
  import xlat_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  hit_any,
  input  logic [WAY_W-1:0]      hit_way,
  input  logic [WAYS-1:0]       vld,
  input  logic [WAY_W-1:0]      plru_way,
  output logic [WAY_W-1:0]      way,
  output fill_src_e             src
);
  logic [WAY_W-1:0] free_way;
  logic             has_free;

  always_comb begin
    free_way = '0;
    has_free = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!vld[i]) begin
        free_way = WAY_W'(i);
        has_free = 1'b1;
      end
  end

  always_comb begin
    if (hit_any) begin
      way = hit_way;  src = FS_MATCH;
    end else if (has_free) begin
      way = free_way; src = FS_FREE;
    end else begin
      way = plru_way; src = FS_PLRU;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int SETS  = 16,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  input  logic             lk_user,
  input  logic             flush_all,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr,
  input  logic             fill_usr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PFN_W-1:0] rsp_pfn
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  // entry storage
  logic [SETS-1:0][WAYS-1:0]             vld_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][PFN_W-1:0]  pfn_q;
  logic [SETS-1:0][WAYS-1:0]             wr_q;
  logic [SETS-1:0][WAYS-1:0]             usr_q;

  // address split
  logic [IDX_W-1:0] lk_idx, inv_idx, f_idx;
  logic [TAG_W-1:0] lk_tag, inv_tag, f_tag;
  assign lk_idx  = lk_vpn[IDX_W-1:0];
  assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
  assign inv_idx = inv_vpn[IDX_W-1:0];
  assign inv_tag = inv_vpn[VPN_W-1:IDX_W];
  assign f_idx   = fill_vpn[IDX_W-1:0];
  assign f_tag   = fill_vpn[VPN_W-1:IDX_W];

  // named events
  logic [WAYS-1:0]  lk_match, inv_match, f_match;
  logic             lk_hit, inv_hit, f_hit;
  logic [WAY_W-1:0] lk_way, inv_way, f_hit_way;
  logic [WAY_W-1:0] plru_way, fill_way;
  fill_src_e        fill_src;
  logic             fill_go, inv_go, lk_touch, lk_fault;

  assign fill_go  = fill_valid && !flush_all && !inv_valid;
  assign inv_go   = inv_valid && inv_hit && !flush_all;
  assign lk_touch = lk_valid && lk_hit && !flush_all;

  xlat_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp_lk (
    .vld(vld_q[lk_idx]), .tags(tag_q[lk_idx]), .key(lk_tag),
    .match(lk_match), .any(lk_hit), .way(lk_way));

  xlat_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp_inv (
    .vld(vld_q[inv_idx]), .tags(tag_q[inv_idx]), .key(inv_tag),
    .match(inv_match), .any(inv_hit), .way(inv_way));

  xlat_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp_fill (
    .vld(vld_q[f_idx]), .tags(tag_q[f_idx]), .key(f_tag),
    .match(f_match), .any(f_hit), .way(f_hit_way));

  xlat_plru_bank #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst_n(rst_n), .clr(flush_all),
    .a_en(lk_touch), .a_set(lk_idx), .a_way(lk_way),
    .b_en(fill_go),  .b_set(f_idx),  .b_way(fill_way),
    .rd_set(f_idx),  .rd_victim(plru_way));

  xlat_victim_sel #(.WAYS(WAYS)) u_vsel (
    .hit_any(f_hit), .hit_way(f_hit_way), .vld(vld_q[f_idx]),
    .plru_way(plru_way), .way(fill_way), .src(fill_src));

  // valid bits: flush > invalidate > refill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush_all) begin
      vld_q <= '0;
    end else begin
      if (inv_go)  vld_q[inv_idx][inv_way] <= 1'b0;
      if (fill_go) vld_q[f_idx][fill_way]  <= 1'b1;
    end
  end

  // payload, written only by an accepted refill
  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[f_idx][fill_way] <= f_tag;
      pfn_q[f_idx][fill_way] <= fill_pfn;
      wr_q[f_idx][fill_way]  <= fill_wr;
      usr_q[f_idx][fill_way] <= fill_usr;
    end
  end

  assign lk_fault = perm_fault(lk_write, lk_user, wr_q[lk_idx][lk_way], usr_q[lk_idx][lk_way]);

  // registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pfn   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit;
      rsp_fault <= lk_valid && lk_hit && lk_fault;
      rsp_pfn   <= (lk_valid && lk_hit) ? pfn_q[lk_idx][lk_way] : '0;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int SETS  = 16,
  parameter int WAYS  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lk_valid,
  input logic [VPN_W-1:0]          lk_vpn,
  input logic                      flush_all,
  input logic                      inv_valid,
  input logic [VPN_W-1:0]          inv_vpn,
  input logic                      rsp_valid,
  input logic                      rsp_hit,
  input logic                      rsp_fault,
  input logic [PFN_W-1:0]          rsp_pfn,
  input logic [WAYS-1:0]           lk_match,
  input logic [SETS-1:0][WAYS-1:0] vld_q
);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r3_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_fault && rsp_pfn == '0));

  a_r4_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);

  a_r5_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld_q == '0));

  a_r8_flush_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all ##1 lk_valid) |=> !rsp_hit);

  a_r9_inv_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid ##1 (lk_valid && lk_vpn == $past(inv_vpn))) |=> !rsp_hit);
endmodule

bind xlat_cache xlat_cache_chk #(
  .VPN_W(VPN_W), .PFN_W(PFN_W), .SETS(SETS), .WAYS(WAYS)
) chk_i (.*);

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [19:0] lk_vpn = '0;
  logic        flush_all = 0, inv_valid = 0, fill_valid = 0, fill_wr = 0, fill_usr = 0;
  logic [19:0] inv_vpn = '0, fill_vpn = '0, fill_pfn = '0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [19:0] rsp_pfn;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_user(lk_user),
    .flush_all(flush_all), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_wr(fill_wr), .fill_usr(fill_usr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn));

  int total = 0, bad = 0;
  bit done = 0;

  // reference model: per set list of slots plus named tree bits
  bit          m_vld [16][4];
  logic [15:0] m_tag [16][4];
  logic [19:0] m_pfn [16][4];
  bit          m_wr  [16][4];
  bit          m_us  [16][4];
  bit          m_root[16], m_left[16], m_right[16];

  function automatic int pick_victim(int s);
    if (!m_root[s]) return m_left[s] ? 1 : 0;
    return m_right[s] ? 3 : 2;
  endfunction

  task automatic use_way(int s, int w);
    case (w)
      0: begin m_root[s] = 1; m_left[s]  = 1; end
      1: begin m_root[s] = 1; m_left[s]  = 0; end
      2: begin m_root[s] = 0; m_right[s] = 1; end
      default: begin m_root[s] = 0; m_right[s] = 0; end
    endcase
  endtask

  function automatic int find(logic [19:0] v);
    for (int w = 0; w < 4; w++)
      if (m_vld[v[3:0]][w] && m_tag[v[3:0]][w] == v[19:4]) return w;
    return -1;
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: predict from model, update model, compare after the edge
  task automatic step(string tag);
    bit e_v, e_h, e_f;
    logic [19:0] e_p;
    int hw, fw, fs, iw;
    e_v = lk_valid; e_h = 0; e_f = 0; e_p = '0; hw = -1;
    if (lk_valid) begin
      hw = find(lk_vpn);
      if (hw >= 0) begin
        e_h = 1;
        e_p = m_pfn[lk_vpn[3:0]][hw];
        e_f = (lk_write && !m_wr[lk_vpn[3:0]][hw]) || (lk_user && !m_us[lk_vpn[3:0]][hw]);
      end
    end
    if (flush_all) begin
      for (int s = 0; s < 16; s++) begin
        for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
        m_root[s] = 0; m_left[s] = 0; m_right[s] = 0;
      end
    end else begin
      fs = int'(fill_vpn[3:0]);
      fw = find(fill_vpn);
      if (fw < 0)
        for (int w = 3; w >= 0; w--) if (!m_vld[fs][w]) fw = w;
      if (fw < 0) fw = pick_victim(fs);
      if (hw >= 0) use_way(int'(lk_vpn[3:0]), hw);
      if (inv_valid) begin
        iw = find(inv_vpn);
        if (iw >= 0) m_vld[inv_vpn[3:0]][iw] = 0;
      end else if (fill_valid) begin
        m_vld[fs][fw] = 1;
        m_tag[fs][fw] = fill_vpn[19:4];
        m_pfn[fs][fw] = fill_pfn;
        m_wr[fs][fw]  = fill_wr;
        m_us[fs][fw]  = fill_usr;
        use_way(fs, fw);
      end
    end
    @(posedge clk); #1;
    cmp(tag, "valid", 32'(rsp_valid), 32'(e_v));
    cmp(tag, "hit",   32'(rsp_hit),   32'(e_h));
    cmp(tag, "fault", 32'(rsp_fault), 32'(e_f));
    cmp(tag, "pfn",   32'(rsp_pfn),   32'(e_p));
  endtask

  task automatic quiet();
    lk_valid = 0; lk_write = 0; lk_user = 0;
    flush_all = 0; inv_valid = 0; fill_valid = 0;
  endtask

  task automatic look(logic [19:0] v, bit wr, bit us, string tag);
    quiet(); lk_valid = 1; lk_vpn = v; lk_write = wr; lk_user = us;
    step(tag); quiet();
  endtask

  task automatic refill(logic [19:0] v, logic [19:0] p, bit wr, bit us, string tag);
    quiet(); fill_valid = 1; fill_vpn = v; fill_pfn = p; fill_wr = wr; fill_usr = us;
    step(tag); quiet();
  endtask

  initial begin
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
      m_root[s] = 0; m_left[s] = 0; m_right[s] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    cmp("R1", "reset valid", 32'(rsp_valid), 0);
    cmp("R1", "reset hit",   32'(rsp_hit),   0);
    cmp("R1", "reset pfn",   32'(rsp_pfn),   0);
    rst_n = 1;
    step("R1");

    // R3: miss on empty array, R1/R4: fill then hit
    look(20'h12345, 0, 0, "R3");
    refill(20'h12345, 20'hABCDE, 1, 1, "R5");
    look(20'h12345, 1, 1, "R4");

    // R2/R6: four pages in set 3 fill ways 0..3
    for (int i = 1; i <= 4; i++) refill(20'(i * 16 + 3), 20'(20'h100 + i), 1, 1, "R6");
    for (int i = 1; i <= 4; i++) look(20'(i * 16 + 3), 0, 1, "R2");
    // R11/R7: touch ways then evict by tree choice
    look(20'h00033, 0, 0, "R11");
    look(20'h00013, 0, 0, "R11");
    refill(20'h00053, 20'h00555, 1, 1, "R7");
    for (int i = 1; i <= 5; i++) look(20'(i * 16 + 3), 0, 0, "R7");
    refill(20'h00063, 20'h00666, 1, 1, "R7");
    for (int i = 1; i <= 6; i++) look(20'(i * 16 + 3), 0, 0, "R7");

    // R4: permissions
    refill(20'h0AAA1, 20'h77777, 0, 0, "R5");
    look(20'h0AAA1, 1, 0, "R4");
    look(20'h0AAA1, 0, 1, "R4");
    look(20'h0AAA1, 0, 0, "R4");
    look(20'h0AAA1, 1, 1, "R4");
    // R5: refill in place
    refill(20'h0AAA1, 20'h13579, 1, 1, "R5");
    look(20'h0AAA1, 1, 1, "R5");
    look(20'h12345, 0, 0, "R5");

    // R9: invalidate one page
    quiet(); inv_valid = 1; inv_vpn = 20'h00053; step("R9"); quiet();
    look(20'h00053, 0, 0, "R9");
    look(20'h00063, 0, 0, "R9");
    // R9: invalidate drops same-cycle refill
    quiet(); inv_valid = 1; inv_vpn = 20'h00013;
    fill_valid = 1; fill_vpn = 20'h00F07; fill_pfn = 20'h0F0F0; fill_wr = 1; fill_usr = 1;
    step("R9"); quiet();
    look(20'h00F07, 0, 0, "R9");
    look(20'h00013, 0, 0, "R9");

    // R10: lookup sees pre-refill state
    quiet(); lk_valid = 1; lk_vpn = 20'h0BEE2;
    fill_valid = 1; fill_vpn = 20'h0BEE2; fill_pfn = 20'h22222; fill_wr = 1; fill_usr = 1;
    step("R10"); quiet();
    look(20'h0BEE2, 0, 0, "R10");

    // R8: flush beats refill
    quiet(); flush_all = 1;
    fill_valid = 1; fill_vpn = 20'h0C0C4; fill_pfn = 20'h44444; fill_wr = 1; fill_usr = 1;
    step("R8"); quiet();
    look(20'h0C0C4, 0, 0, "R8");
    look(20'h12345, 0, 0, "R8");
    look(20'h0BEE2, 0, 0, "R8");
    // R11: tree cleared by flush
    for (int i = 1; i <= 5; i++) refill(20'(i * 16 + 9), 20'(i), 1, 1, "R11");
    for (int i = 1; i <= 5; i++) look(20'(i * 16 + 9), 0, 0, "R11");

    // mixed random traffic on a small page pool
    for (int n = 0; n < 400; n++) begin
      quiet();
      lk_valid  = ($urandom_range(0, 9) < 7);
      lk_vpn    = {12'h0, 4'($urandom_range(0, 5)), 4'($urandom_range(0, 1))};
      lk_write  = 1'($urandom_range(0, 1));
      lk_user   = 1'($urandom_range(0, 1));
      flush_all = ($urandom_range(0, 49) == 0);
      inv_valid = ($urandom_range(0, 9) == 0);
      inv_vpn   = {12'h0, 4'($urandom_range(0, 5)), 4'($urandom_range(0, 1))};
      fill_valid = ($urandom_range(0, 9) < 4);
      fill_vpn  = {12'h0, 4'($urandom_range(0, 5)), 4'($urandom_range(0, 1))};
      fill_pfn  = 20'($urandom);
      fill_wr   = 1'($urandom_range(0, 1));
      fill_usr  = 1'($urandom_range(0, 1));
      step("R7");
    end
    quiet();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule